// File: doc/BRIEF.md
# Peripheral Security Attribute Controller

This block is a bank of security settings read and written over a plain 32-bit register bus. It keeps a 2-bit access attribute for each securable peripheral and a 16-bit read-only size for each protected on-chip memory region, and drives every attribute and size onto flat output vectors that downstream bus firewalls decode. Each peripheral and each region has a sticky lock. Once a lock is set, only a reset clears it, and it freezes the setting it guards.

Writes take effect only when the bus marks them as secure. Reads are combinational from the word address. The block also answers with two constant words: one gives its configuration (region count, peripheral count, master count, size step code) and one gives its revision. Any offset that is not mapped reads as zero. Any field that lies past the configured peripheral or region count also reads as zero.

Top module: `sec_attr_ctrl`

## Requirements
- R1: After reset, every attribute, region size, region lock and peripheral lock is zero, on both the read bus and the output vectors.
- R2: Region r's register sits at byte offset 4*r. Bits [15:0] hold its size, which is mirrored on region_size[16r+15:16r]. Bits [30:16] read as zero.
- R3: Bit 31 of a region register is that region's lock and reads back as such. Once it is set, every write to that register is ignored until reset. Other regions stay writable.
- R4: Peripheral n's attribute lies in the word at offset 0x010 + 4*(n/16), bits [2*(n%16)+1 : 2*(n%16)], and is mirrored on periph_attr[2n+1:2n].
- R5: Peripheral n's lock is bit n%32 of the word at offset 0x030 + 4*(n/32). Writing 1 sets the lock and writing 0 leaves it unchanged, so the locks are write-one-to-set and sticky.
- R6: While peripheral n is locked, writes leave its 2-bit field unchanged, and the other fields of the same word still update.
- R7: A write with bus_wr_secure low changes no attribute, size or lock.
- R8: Offset 0x3F0 reads {size step code[31:24], master count[23:16], peripheral count[15:8], region count[7:0]}.
- R9: Offset 0x3F4 reads the revision in bits [7:0], with zeros above.
- R10: Unmapped offsets read zero. Fields and words past the configured peripheral or region count read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wr_secure | input | 1 | Write issued by a secure initiator |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| periph_attr | output | 2*NUM_PERIPH | Attribute of each peripheral, 2 bits each |
| region_size | output | 16*NUM_REGION | Read-only size of each region, 16 bits each |

## Verification
The bench builds the block with 40 peripherals and 3 regions so that partly filled and empty words exist. Attribute writes use sparse patterns (low fields, the top field of a word, and the third word) to separate correct packing from shifted or swapped fields. An all-ones-and-zeros pattern applied to a word that holds a locked peripheral shows whether the lock masks only its own field. Lock writes of zero, of single bits and of wide masks past the count show the difference between write-one-to-set, overwrite, and storage of lock bits that do not exist.

// File: rtl/sec_attr_pkg.sv
// Shared constants and types for the security attribute controller.
// Word offsets are byte offsets divided by four.
package sec_attr_pkg;
    localparam logic [31:0] REGION_WORD0 = 32'h000;
    localparam logic [31:0] ATTR_WORD0   = 32'h004;
    localparam logic [31:0] LOCK_WORD0   = 32'h00C;
    localparam logic [31:0] HWCFG_WORD   = 32'h0FC;
    localparam logic [31:0] VER_WORD     = 32'h0FD;
    localparam int          IDX_W        = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REGION,
        SEL_ATTR,
        SEL_LOCK,
        SEL_HWCFG,
        SEL_VER
    } sel_kind_e;
endpackage

// File: rtl/sat_addr_decode.sv
// Address decoder: maps a byte address onto a register kind and a word index
// within that kind. It assumes word-aligned addresses and ignores bits [1:0].
module sat_addr_decode
    import sec_attr_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int NUM_REGION = 4,
    parameter int ATTR_WORDS = 4,
    parameter int LOCK_WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [31:0] word;
    logic [31:0] rel;
    logic [1:0]  unused_lsb;

    assign word       = 32'(addr[ADDR_W-1:2]);
    assign unused_lsb = addr[1:0];

    // Classify the word address and compute the index within its group.
    always_comb begin
        kind = SEL_NONE;
        rel  = '0;
        if (word < 32'(NUM_REGION)) begin
            kind = SEL_REGION;
            rel  = word - REGION_WORD0;
        end else if (word >= ATTR_WORD0 && word < ATTR_WORD0 + 32'(ATTR_WORDS)) begin
            kind = SEL_ATTR;
            rel  = word - ATTR_WORD0;
        end else if (word >= LOCK_WORD0 && word < LOCK_WORD0 + 32'(LOCK_WORDS)) begin
            kind = SEL_LOCK;
            rel  = word - LOCK_WORD0;
        end else if (word == HWCFG_WORD) begin
            kind = SEL_HWCFG;
        end else if (word == VER_WORD) begin
            kind = SEL_VER;
        end
        idx = rel[IDX_W-1:0];
    end
endmodule

// File: rtl/sat_periph_bank.sv
// Peripheral bank: holds a 2-bit attribute and a sticky lock for each peripheral.
// Attributes are packed 16 per word and locks 32 per word. A lock freezes only
// its own attribute field. Assumes write strobes are already qualified as secure.
module sat_periph_bank
    import sec_attr_pkg::*;
#(
    parameter int NUM_PERIPH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    attr_we,
    input  logic                    lock_we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [31:0]             wdata,
    output logic [31:0]             attr_rword,
    output logic [31:0]             lock_rword,
    output logic [2*NUM_PERIPH-1:0] attr_flat
);
    logic [1:0]            attr_q [NUM_PERIPH];
    logic [NUM_PERIPH-1:0] lock_q;

    for (genvar n = 0; n < NUM_PERIPH; n++) begin : g_per
        localparam int AW = n / 16;
        localparam int AB = 2 * (n % 16);
        localparam int LW = n / 32;
        localparam int LB = n % 32;

        // Attribute update, blocked while this peripheral is locked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                attr_q[n] <= 2'b00;
            else if (attr_we && idx == IDX_W'(AW) && !lock_q[n])
                attr_q[n] <= wdata[AB +: 2];
        end

        // Lock bit: set by writing one, cleared only by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lock_q[n] <= 1'b0;
            else if (lock_we && idx == IDX_W'(LW) && wdata[LB])
                lock_q[n] <= 1'b1;
        end

        assign attr_flat[2*n +: 2] = attr_q[n];

        // R6
        locked_attr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[n] |=> $stable(attr_q[n]));
    end

    // Assemble the attribute word selected by idx.
    always_comb begin
        attr_rword = '0;
        for (int n = 0; n < NUM_PERIPH; n++)
            if (n / 16 == int'(idx)) attr_rword[2*(n%16) +: 2] = attr_q[n];
    end

    // Assemble the lock word selected by idx.
    always_comb begin
        lock_rword = '0;
        for (int n = 0; n < NUM_PERIPH; n++)
            if (n / 32 == int'(idx)) lock_rword[n%32] = lock_q[n];
    end

    // R5
    periph_lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
endmodule

// File: rtl/sat_region_bank.sv
// Region bank: a 16-bit read-only size and a lock (bit 31) for each region.
// A locked region ignores every write. Assumes the strobe is already qualified as secure.
module sat_region_bank
    import sec_attr_pkg::*;
#(
    parameter int NUM_REGION = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [31:0]              wdata,
    output logic [31:0]              rword,
    output logic [16*NUM_REGION-1:0] size_flat
);
    logic [15:0]           size_q [NUM_REGION];
    logic [NUM_REGION-1:0] lock_q;
    logic [14:0]           unused_wbits;

    assign unused_wbits = wdata[30:16];

    for (genvar r = 0; r < NUM_REGION; r++) begin : g_reg
        // Size and lock update while the region is still open.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                size_q[r] <= '0;
                lock_q[r] <= 1'b0;
            end else if (we && idx == IDX_W'(r) && !lock_q[r]) begin
                size_q[r] <= wdata[15:0];
                lock_q[r] <= wdata[31];
            end
        end

        assign size_flat[16*r +: 16] = size_q[r];

        // R3
        region_locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_q[r] |=> ($stable(size_q[r]) && lock_q[r]));
    end

    // Read word for the selected region: lock, zero gap, size.
    always_comb begin
        rword = '0;
        for (int r = 0; r < NUM_REGION; r++)
            if (r == int'(idx)) rword = {lock_q[r], 15'b0, size_q[r]};
    end
endmodule

// File: rtl/sec_attr_ctrl.sv
// Top level of the peripheral security attribute controller. It decodes the bus,
// drops non-secure writes, steers write strobes to the banks and multiplexes read
// data. Assumes single-cycle write strobes and word-aligned addresses.
module sec_attr_ctrl
    import sec_attr_pkg::*;
#(
    parameter int          ADDR_W     = 10,
    parameter int          NUM_PERIPH = 64,
    parameter int          NUM_REGION = 4,
    parameter int          NUM_MASTER = 8,
    parameter logic [7:0]  SIZE_STEP  = 8'h02,
    parameter logic [7:0]  REVISION   = 8'h20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr_en,
    input  logic                     bus_wr_secure,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic [2*NUM_PERIPH-1:0]  periph_attr,
    output logic [16*NUM_REGION-1:0] region_size
);
    localparam int ATTR_WORDS = (NUM_PERIPH + 15) / 16;
    localparam int LOCK_WORDS = (NUM_PERIPH + 31) / 32;
    localparam logic [31:0] HWCFG_VAL =
        {SIZE_STEP, 8'(NUM_MASTER), 8'(NUM_PERIPH), 8'(NUM_REGION)};

    sel_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             wr_ok;
    logic [31:0]      attr_rword, lock_rword, region_rword;

    sat_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_REGION(NUM_REGION),
        .ATTR_WORDS(ATTR_WORDS), .LOCK_WORDS(LOCK_WORDS)
    ) i_decode (
        .addr(bus_addr), .kind(kind), .idx(idx)
    );

    assign wr_ok = bus_wr_en && bus_wr_secure;

    sat_periph_bank #(.NUM_PERIPH(NUM_PERIPH)) i_periph (
        .clk(clk), .rst_n(rst_n),
        .attr_we(wr_ok && kind == SEL_ATTR),
        .lock_we(wr_ok && kind == SEL_LOCK),
        .idx(idx), .wdata(bus_wdata),
        .attr_rword(attr_rword), .lock_rword(lock_rword),
        .attr_flat(periph_attr)
    );

    sat_region_bank #(.NUM_REGION(NUM_REGION)) i_region (
        .clk(clk), .rst_n(rst_n),
        .we(wr_ok && kind == SEL_REGION),
        .idx(idx), .wdata(bus_wdata),
        .rword(region_rword), .size_flat(region_size)
    );

    // Read data multiplexer by register kind.
    always_comb begin
        case (kind)
            SEL_REGION: bus_rdata = region_rword;
            SEL_ATTR:   bus_rdata = attr_rword;
            SEL_LOCK:   bus_rdata = lock_rword;
            SEL_HWCFG:  bus_rdata = HWCFG_VAL;
            SEL_VER:    bus_rdata = {24'b0, REVISION};
            default:    bus_rdata = '0;
        endcase
    end

    // R7
    nonsecure_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !bus_wr_secure) |=> ($stable(periph_attr) && $stable(region_size)));

    // R10
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SEL_NONE) |-> (bus_rdata == 32'b0));
endmodule

// File: tb/test_sec_attr_ctrl.sv
// Directed bench for the security attribute controller (40 peripherals, 3 regions).
module test_sec_attr_ctrl;
    localparam int NP = 40;
    localparam int NR = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [9:0]       bus_addr = '0;
    logic             bus_wr_en = 1'b0;
    logic             bus_wr_secure = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [2*NP-1:0]  periph_attr;
    logic [16*NR-1:0] region_size;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sec_attr_ctrl #(
        .ADDR_W(10), .NUM_PERIPH(NP), .NUM_REGION(NR), .NUM_MASTER(6),
        .SIZE_STEP(8'h03), .REVISION(8'h21)
    ) i_sec_attr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wr_secure(bus_wr_secure), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_attr(periph_attr), .region_size(region_size)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_secure = sec; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wr_secure = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [9:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // R1: everything reads zero after reset.
    task automatic t_reset_state();
        read_check("R1", 10'h000, 32'h0);
        read_check("R1", 10'h004, 32'h0);
        read_check("R1", 10'h010, 32'h0);
        read_check("R1", 10'h018, 32'h0);
        read_check("R1", 10'h030, 32'h0);
        read_check("R1", 10'h034, 32'h0);
        check("R1", 32'(periph_attr[31:0]), 32'h0);
        check("R1", 32'(region_size[31:0]), 32'h0);
    endtask

    // R2: size field placement and zero gap.
    task automatic t_region_size();
        bus_write(10'h004, 32'h0000_1234, 1'b1);
        read_check("R2", 10'h004, 32'h0000_1234);
        check("R2", 32'(region_size[31:16]), 32'h1234);
        bus_write(10'h004, 32'h00FF_ABCD, 1'b1);
        read_check("R2", 10'h004, 32'h0000_ABCD);
    endtask

    // R3: region lock freezes only its own register.
    task automatic t_region_lock();
        bus_write(10'h004, 32'h8000_ABCD, 1'b1);
        read_check("R3", 10'h004, 32'h8000_ABCD);
        bus_write(10'h004, 32'h0000_5555, 1'b1);
        read_check("R3", 10'h004, 32'h8000_ABCD);
        check("R3", 32'(region_size[31:16]), 32'hABCD);
        bus_write(10'h000, 32'h0000_0077, 1'b1);
        read_check("R3", 10'h000, 32'h0000_0077);
    endtask

    // R4: attribute packing across three words.
    task automatic t_attr_packing();
        bus_write(10'h010, 32'h0000_0C09, 1'b1);
        check("R4", 32'(periph_attr[11:0]), 32'hC09);
        bus_write(10'h014, 32'hC000_0001, 1'b1);
        check("R4", 32'(periph_attr[33:32]), 32'h1);
        check("R4", 32'(periph_attr[63:62]), 32'h3);
        read_check("R4", 10'h014, 32'hC000_0001);
        bus_write(10'h018, 32'h0000_0008, 1'b1);
        check("R4", 32'(periph_attr[67:66]), 32'h2);
    endtask

    // R5: write-one-to-set locks.
    task automatic t_locks();
        bus_write(10'h030, 32'h0000_0020, 1'b1);
        read_check("R5", 10'h030, 32'h0000_0020);
        bus_write(10'h030, 32'h0000_0000, 1'b1);
        read_check("R5", 10'h030, 32'h0000_0020);
        bus_write(10'h030, 32'h0000_0002, 1'b1);
        read_check("R5", 10'h030, 32'h0000_0022);
        bus_write(10'h034, 32'h0000_0002, 1'b1);
        read_check("R5", 10'h034, 32'h0000_0002);
    endtask

    // R6: locked fields hold, neighbours update (p1, p5, p33 locked).
    task automatic t_locked_fields();
        bus_write(10'h010, 32'h0000_0000, 1'b1);
        read_check("R6", 10'h010, 32'h0000_0C08);
        bus_write(10'h010, 32'h5555_5555, 1'b1);
        read_check("R6", 10'h010, 32'h5555_5D59);
        check("R6", 32'(periph_attr[11:10]), 32'h3);
        bus_write(10'h018, 32'h0000_0000, 1'b1);
        read_check("R6", 10'h018, 32'h0000_0008);
    endtask

    // R7: non-secure writes dropped.
    task automatic t_nonsecure();
        bus_write(10'h000, 32'h0000_1111, 1'b0);
        read_check("R7", 10'h000, 32'h0000_0077);
        bus_write(10'h030, 32'h0000_FFFF, 1'b0);
        read_check("R7", 10'h030, 32'h0000_0022);
        bus_write(10'h014, 32'h0000_0000, 1'b0);
        read_check("R7", 10'h014, 32'hC000_0001);
    endtask

    // R8, R9: constant configuration and revision words.
    task automatic t_id_regs();
        read_check("R8", 10'h3F0, 32'h0306_2803);
        read_check("R9", 10'h3F4, 32'h0000_0021);
    endtask

    // R10: unmapped offsets and beyond-count fields.
    task automatic t_unmapped();
        read_check("R10", 10'h020, 32'h0);
        read_check("R10", 10'h3F8, 32'h0);
        read_check("R10", 10'h100, 32'h0);
        bus_write(10'h01C, 32'hFFFF_FFFF, 1'b1);
        read_check("R10", 10'h01C, 32'h0);
        bus_write(10'h018, 32'hFFFF_0008, 1'b1);
        read_check("R10", 10'h018, 32'h0000_0008);
        bus_write(10'h034, 32'hFFFF_FF00, 1'b1);
        read_check("R10", 10'h034, 32'h0000_0002);
        bus_write(10'h00C, 32'h0000_1234, 1'b1);
        read_check("R10", 10'h00C, 32'h0);
    endtask

    // R1: a second reset clears locks and reopens registers.
    task automatic t_reset_clears_locks();
        do_reset();
        read_check("R1", 10'h004, 32'h0);
        read_check("R1", 10'h030, 32'h0);
        check("R1", 32'(periph_attr[11:10]), 32'h0);
        bus_write(10'h004, 32'h0000_0042, 1'b1);
        read_check("R1", 10'h004, 32'h0000_0042);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_region_size();
        t_region_lock();
        t_attr_packing();
        t_locks();
        t_locked_fields();
        t_nonsecure();
        t_id_regs();
        t_unmapped();
        t_reset_clears_locks();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule